// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block is the central interrupt controller of a small multiprocessor. It watches 32 level-sensitive device request lines and one timer line per CPU. It records their transitions in a 32-bit pending register and masks that register with a 32-bit disable register. Each source bit is translated to a 4-bit priority level. The resulting 16-bit level vector goes to one CPU, and software picks that CPU through a target register.

Software reaches the pending, disable and target state through a single-cycle register port. The port takes a byte address. Enabling is done by writing a set of bits to one word, and disabling by writing a set of bits to another word. A disable write also discards any pending request on the bits it names. The upper bit of the disable register stops all device traffic at once. Each CPU's soft-interrupt bits come in on an input vector and are merged into that CPU's level vector whatever the target and the global disable say.

Top module: `intr_router`

## Requirements
- R1: After a synchronous active-low reset, pending is zero, the disable register holds 0x0FA2007F (every implemented source enabled, global disable off), the target is CPU 0 and every level output is zero.
- R2: The register word index is the byte address shifted right by two. Index 0 reads pending, index 1 reads disable, index 4 reads and writes the target. Indices 0, 1, 5, 6 and 7 ignore writes. Indices 2, 3, 5, 6 and 7 read as zero. Read data is zero unless a read (valid high, write low) is presented.
- R3: A write to index 2 clears the disable bits set in the data ANDed with ~0x0FA2007F, which enables those sources.
- R4: A write to index 3 sets the disable bits set in the data ANDed with ~0x0FA2007F. It also clears the same pending bits, and this clear wins over a rising edge on those bits in the same cycle.
- R5: A read of index 0 returns pending with bit 31 forced to zero. A read of index 1 returns disable ANDed with ~0x0FA2007F.
- R6: While disable bit 31 is set, no device-derived level bit reaches any CPU.
- R7: The target register takes the write data ANDed with (NCPU-1). Only the target CPU receives level bits derived from enabled pending sources.
- R8: Source bit j has level j mod 16. An enabled pending bit j sets bit (j mod 16) of the target's level vector. Sources with level 0 (bits 0 and 16) never set a pending bit.
- R9: A rising edge on a device input sets its pending bit and a falling edge clears it. If a set and a clear fall on one bit in the same cycle, the set wins.
- R10: A rising edge on any CPU's timer input sets pending bit 14 (the timer source, level 14). A falling edge on any timer input clears it.
- R11: The 16 soft-interrupt bits of CPU i (soft_in[16i+15:16i]) are ORed into that CPU's level vector, independent of target and global disable.
- R12: Level outputs are registered from the current state. A register write or an input edge sampled at one clock edge reaches lvl_req at the following edge. A soft-input change reaches it at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Level-sensitive device request lines |
| tmr_in | input | NCPU | Per-CPU timer request lines |
| soft_in | input | NCPU*16 | Per-CPU soft-interrupt level bits, 16 per CPU |
| reg_vld | input | 1 | Register access valid |
| reg_wr | input | 1 | Access is a write when high |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the access |
| lvl_req | output | NCPU*16 | Per-CPU level request vectors, 16 bits per CPU |

## Verification
Directed phases raise device lines one at a time under target 0. This shows the j-mod-16 mapping and the inertness of level-0 sources apart from a plain pass-through. Retargeting, global disable and disable writes made while a line is still high tell steering, the kill bit and the discard-pending behaviour apart. Timer edges on different CPUs show that the shared pending bit follows any CPU. A long phase of sparse random edges, random soft bits and random accesses to all eight word indices puts sets and clears in the same cycle. The behavioural model is compared on every clock to find ordering errors.

// File: rtl/intr_router_pkg.sv
// Package: shared constants and the source-to-level mapping of the router.
// Assumes 32 sources, 16 levels and a 32-bit register word.
package intr_router_pkg;

    localparam int DATA_W   = 32;
    localparam int NSRC     = 32;
    localparam int LVL_W    = 4;
    localparam int NLVL     = 1 << LVL_W;
    localparam int KILL_BIT = 31;

    // Bits that are not maskable sources; they stay disabled for good.
    localparam logic [DATA_W-1:0] FIXED_MASK = 32'h0FA2_007F;
    localparam logic [DATA_W-1:0] IMPL_MASK  = ~FIXED_MASK;

    // Register word indices (byte address >> 2).
    typedef enum logic [2:0] {
        W_PEND = 3'd0,
        W_DIS  = 3'd1,
        W_ENA  = 3'd2,
        W_DSET = 3'd3,
        W_TGT  = 3'd4
    } word_e;

    // Priority level of source bit j.
    function automatic logic [LVL_W-1:0] src_level(input int unsigned j);
        return LVL_W'(j % NLVL);
    endfunction

    // Mask of sources whose level is non-zero (the others are inert).
    function automatic logic [NSRC-1:0] live_mask();
        logic [NSRC-1:0] m;
        for (int j = 0; j < NSRC; j++) begin
            m[j] = (src_level(j) != '0);
        end
        return m;
    endfunction

endpackage

// File: rtl/intr_router_pend.sv
// Pending stage: detects edges on device and timer lines and keeps the
// 32-bit pending register. Assumes inputs are synchronous to clk.
// Rising edges win over falling edges; a disable-write clear wins over both.
module intr_router_pend
    import intr_router_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int TMR_SRC = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic [NCPU-1:0]   tmr_in,
    input  logic [NSRC-1:0]   clr_mask,
    output logic [NSRC-1:0]   pend_o
);

    localparam logic [NSRC-1:0] LIVE    = live_mask();
    localparam logic [NSRC-1:0] TMR_BIT = NSRC'(1) << TMR_SRC;

    logic [NSRC-1:0] src_q;
    logic [NCPU-1:0] tmr_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] fall;
    logic            tmr_rise;
    logic            tmr_fall;

    // Edge terms for every source bit, timer edges folded into the timer bit.
    always_comb begin
        tmr_rise = |(tmr_in & ~tmr_q);
        tmr_fall = |(~tmr_in & tmr_q);
        rise     = (src_in & ~src_q & LIVE) | (tmr_rise ? TMR_BIT : '0);
        fall     = (~src_in & src_q & LIVE) | (tmr_fall ? TMR_BIT : '0);
    end

    // Input history and pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            tmr_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_in;
            tmr_q  <= tmr_in;
            pend_q <= ((pend_q & ~fall) | rise) & ~clr_mask;
        end
    end

    assign pend_o = pend_q;

    // Level-0 sources never become pending.
    p_inert_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~LIVE) == '0);

    // A device rising edge not hit by a clear shows as pending next cycle.
    generate
        for (genvar j = 0; j < NSRC; j++) begin : g_chk
            if (LIVE[j]) begin : g_live
                p_rise_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    (src_in[j] && !src_q[j] && !clr_mask[j]) |=> pend_q[j]);
            end
        end
    endgenerate

endmodule

// File: rtl/intr_router_regs.sv
// Register port: decodes the word index, keeps the disable and target
// registers, produces the pending clear mask and the read data.
// Assumes a single-cycle access; read data is combinational.
module intr_router_regs
    import intr_router_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_vld,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic [NSRC-1:0]           pend_i,
    output logic [DATA_W-1:0]         dis_o,
    output logic [$clog2(NCPU)-1:0]   tgt_o,
    output logic [NSRC-1:0]           clr_mask_o,
    output logic [DATA_W-1:0]         reg_rdata
);

    localparam int TGT_W = $clog2(NCPU);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] wsel;
    logic [DATA_W-1:0] dis_q;
    logic [TGT_W-1:0]  tgt_q;
    logic              unused_lsb;

    assign widx       = reg_addr[ADDR_W-1:2];
    assign unused_lsb = ^reg_addr[1:0];
    assign wr_en      = reg_vld && reg_wr;
    assign rd_en      = reg_vld && !reg_wr;
    assign wsel       = reg_wdata & IMPL_MASK;

    // Disable and target registers, written by index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= FIXED_MASK;
            tgt_q <= '0;
        end else if (wr_en) begin
            if (widx == IDX_W'(W_ENA))  dis_q <= dis_q & ~wsel;
            if (widx == IDX_W'(W_DSET)) dis_q <= dis_q | wsel;
            if (widx == IDX_W'(W_TGT))  tgt_q <= reg_wdata[TGT_W-1:0];
        end
    end

    // Pending bits dropped by a disable write.
    always_comb begin
        clr_mask_o = (wr_en && widx == IDX_W'(W_DSET)) ? wsel : '0;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            case (widx)
                IDX_W'(W_PEND): reg_rdata = pend_i & ~(DATA_W'(1) << KILL_BIT);
                IDX_W'(W_DIS):  reg_rdata = dis_q & IMPL_MASK;
                IDX_W'(W_TGT):  reg_rdata = {{(DATA_W-TGT_W){1'b0}}, tgt_q};
                default:        reg_rdata = '0;
            endcase
        end
    end

    assign dis_o = dis_q;
    assign tgt_o = tgt_q;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (dis_q == FIXED_MASK) && (tgt_q == '0));

    p_tgt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == IDX_W'(W_TGT)) |=> (tgt_q == $past(reg_wdata[TGT_W-1:0])));

    p_dead_words_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx > IDX_W'(W_TGT)) |=> ($stable(dis_q) && $stable(tgt_q)));

    p_dset_drops_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == IDX_W'(W_DSET)) |=> ((pend_i & $past(wsel)) == '0));

endmodule

// File: rtl/intr_router_fanout.sv
// Fan-out stage: turns enabled pending bits into a level vector, steers it
// to the target CPU unless globally disabled, merges soft bits and registers
// one 16-bit vector per CPU.
module intr_router_fanout
    import intr_router_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           pend_i,
    input  logic [DATA_W-1:0]         dis_i,
    input  logic [$clog2(NCPU)-1:0]   tgt_i,
    input  logic [NCPU*NLVL-1:0]      soft_in,
    output logic [NCPU*NLVL-1:0]      lvl_o
);

    localparam int TGT_W = $clog2(NCPU);

    logic [NSRC-1:0] active;
    logic [NLVL-1:0] dev_vec;
    logic            kill;

    // Shared level encoder for the enabled pending set.
    always_comb begin
        active  = pend_i & ~dis_i;
        kill    = dis_i[KILL_BIT];
        dev_vec = '0;
        for (int j = 0; j < NSRC; j++) begin
            if (active[j]) dev_vec[src_level(j)] = 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < NCPU; i++) begin : g_cpu
            logic [NLVL-1:0] out_q;
            logic            sel;

            assign sel = (tgt_i == TGT_W'(i)) && !kill;

            // Per-CPU output register.
            always_ff @(posedge clk) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= (sel ? dev_vec : '0) | soft_in[i*NLVL +: NLVL];
            end

            assign lvl_o[i*NLVL +: NLVL] = out_q;

            p_kill_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
                dis_i[KILL_BIT] |=> (out_q == $past(soft_in[i*NLVL +: NLVL])));

            p_other_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (tgt_i != TGT_W'(i)) |=> (out_q == $past(soft_in[i*NLVL +: NLVL])));

            p_soft_merge_r11: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((out_q & $past(soft_in[i*NLVL +: NLVL]))
                          == $past(soft_in[i*NLVL +: NLVL])));
        end
    endgenerate

endmodule

// File: rtl/intr_router.sv
// Top: system interrupt router. Connects the pending stage, the register
// port and the fan-out stage. NCPU must be a power of two, at least 2;
// TMR_SRC must name a source with a non-zero level.
module intr_router
    import intr_router_pkg::*;
#(
    parameter int NCPU    = 4,
    parameter int ADDR_W  = 5,
    parameter int TMR_SRC = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_in,
    input  logic [NCPU-1:0]        tmr_in,
    input  logic [NCPU*NLVL-1:0]   soft_in,
    input  logic                   reg_vld,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [NCPU*NLVL-1:0]   lvl_req
);

    localparam int TGT_W = $clog2(NCPU);

    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   clr_mask;
    logic [DATA_W-1:0] dis;
    logic [TGT_W-1:0]  tgt;

    intr_router_pend #(.NCPU(NCPU), .TMR_SRC(TMR_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .tmr_in   (tmr_in),
        .clr_mask (clr_mask),
        .pend_o   (pend)
    );

    intr_router_regs #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_vld    (reg_vld),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pend_i     (pend),
        .dis_o      (dis),
        .tgt_o      (tgt),
        .clr_mask_o (clr_mask),
        .reg_rdata  (reg_rdata)
    );

    intr_router_fanout #(.NCPU(NCPU)) u_fan (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .dis_i   (dis),
        .tgt_i   (tgt),
        .soft_in (soft_in),
        .lvl_o   (lvl_req)
    );

    p_timer_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(tmr_in & ~$past(tmr_in))) && !clr_mask[TMR_SRC]) |=> pend[TMR_SRC]);

endmodule

// File: tb/intr_router_tb_top.sv
// Bench: drives directed and random traffic, keeps a behavioural model of
// the router and compares outputs and read data on every clock.
module intr_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU   = 4;
    localparam int ADDR_W = 5;
    localparam int TMR    = 14;
    localparam logic [31:0] FIXED = 32'h0FA2_007F;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [31:0]          src_in = '0;
    logic [NCPU-1:0]      tmr_in = '0;
    logic [NCPU*16-1:0]   soft_in = '0;
    logic                 reg_vld = 1'b0;
    logic                 reg_wr = 1'b0;
    logic [ADDR_W-1:0]    reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic [NCPU*16-1:0]   lvl_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_router #(.NCPU(NCPU), .ADDR_W(ADDR_W), .TMR_SRC(TMR)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .tmr_in(tmr_in),
        .soft_in(soft_in), .reg_vld(reg_vld), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lvl_req(lvl_req)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Behavioural model state.
    logic [31:0]     m_pend, m_dis, m_prev_src;
    logic [NCPU-1:0] m_prev_tmr;
    int              m_tgt;
    logic [15:0]     m_out [NCPU];

    function automatic logic [31:0] m_read();
        int idx;
        idx = int'(reg_addr) / 4;
        if (!(reg_vld && !reg_wr)) return 32'h0;
        if (idx == 0) return m_pend & 32'h7FFF_FFFF;
        if (idx == 1) return m_dis & ~FIXED;
        if (idx == 4) return 32'(m_tgt);
        return 32'h0;
    endfunction

    // Model update on each rising edge, from inputs driven after the prior edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_pend = 0; m_dis = FIXED; m_tgt = 0; m_prev_src = 0; m_prev_tmr = 0;
            for (int i = 0; i < NCPU; i++) m_out[i] = 0;
        end else begin
            logic [15:0] dv;
            logic [31:0] st, cl;
            bit          trise, tfall;
            int          idx;
            dv = 0;
            for (int j = 0; j < 32; j++)
                if (m_pend[j] && !m_dis[j]) dv[j % 16] = 1'b1;
            for (int i = 0; i < NCPU; i++)
                m_out[i] = soft_in[i*16 +: 16] | ((i == m_tgt && !m_dis[31]) ? dv : 16'h0);
            st = 0; cl = 0; trise = 0; tfall = 0;
            for (int j = 0; j < 32; j++) begin
                if (j % 16 != 0) begin
                    if (src_in[j] && !m_prev_src[j]) st[j] = 1'b1;
                    if (!src_in[j] && m_prev_src[j]) cl[j] = 1'b1;
                end
            end
            for (int i = 0; i < NCPU; i++) begin
                if (tmr_in[i] && !m_prev_tmr[i]) trise = 1;
                if (!tmr_in[i] && m_prev_tmr[i]) tfall = 1;
            end
            if (trise) st[TMR] = 1'b1;
            if (tfall) cl[TMR] = 1'b1;
            m_pend = (m_pend & ~cl) | st;
            idx = int'(reg_addr) / 4;
            if (reg_vld && reg_wr) begin
                if (idx == 2) m_dis = m_dis & ~(reg_wdata & ~FIXED);
                if (idx == 3) begin
                    m_dis  = m_dis | (reg_wdata & ~FIXED);
                    m_pend = m_pend & ~(reg_wdata & ~FIXED);
                end
                if (idx == 4) m_tgt = int'(reg_wdata) & (NCPU - 1);
            end
            m_prev_src = src_in;
            m_prev_tmr = tmr_in;
        end
    end

    // Compare away from the rising edge.
    always @(negedge clk) begin
        if (started && !done) begin
            for (int i = 0; i < NCPU; i++) begin
                n_cmp++;
                if (lvl_req[i*16 +: 16] !== m_out[i]) begin
                    n_bad++;
                    $display("FAIL %s: lvl_req cpu%0d actual %h expected %h at %0t",
                             cur_req, i, lvl_req[i*16 +: 16], m_out[i], $time);
                end
            end
            n_cmp++;
            if (reg_rdata !== m_read()) begin
                n_bad++;
                $display("FAIL %s: reg_rdata word %0d actual %h expected %h at %0t",
                         cur_req, reg_addr / 4, reg_rdata, m_read(), $time);
            end
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        reg_vld = 1; reg_wr = 1; reg_addr = ADDR_W'(idx * 4); reg_wdata = d;
        cyc();
        reg_vld = 0; reg_wr = 0;
    endtask

    task automatic rd(input int idx);
        reg_vld = 1; reg_wr = 0; reg_addr = ADDR_W'(idx * 4 + 1);
        cyc();
        reg_vld = 0;
    endtask

    task automatic rd_all();
        for (int k = 0; k < 8; k++) rd(k);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        cyc(3);
        rst_n = 1;
        cyc(2);
        rd_all();

        // R2: dead words ignore writes, reads of unused words are zero
        cur_req = "R2";
        wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF); wr(6, 32'h8000_0000); wr(7, 32'h3);
        rd_all();

        // R3: enable writes
        cur_req = "R3";
        wr(3, 32'hFFFF_FFFF);
        rd(1);
        wr(2, 32'h0000_FF00);
        rd(1);
        wr(2, 32'hFFFF_FFFF);
        rd(1);

        // R8/R9: single-source levels at target 0, including level-0 sources
        cur_req = "R8";
        for (int j = 0; j < 32; j++) begin
            src_in[j] = 1'b1; cyc(2); rd(0);
            src_in[j] = 1'b0; cyc(2); rd(0);
        end
        cur_req = "R9";
        src_in = 32'h0000_8180; cyc(2); rd(0);
        src_in = 32'h0000_0000; cyc(2); rd(0);

        // R5: bit 31 pending, hidden on read
        cur_req = "R5";
        src_in[31] = 1'b1; cyc(2); rd(0); rd(1);

        // R7: retarget
        cur_req = "R7";
        src_in[9] = 1'b1; cyc(2);
        wr(4, 32'hFFFF_FFFE); cyc(2); rd(4);
        wr(4, 32'h0000_0007); cyc(2); rd(4);
        wr(4, 32'h0000_0001); cyc(2);

        // R6: global disable and release
        cur_req = "R6";
        src_in[20] = 1'b1; cyc(2);
        wr(3, 32'h8000_0000); cyc(3); rd(1);
        src_in[12] = 1'b1; cyc(3);
        wr(2, 32'h8000_0000); cyc(3);

        // R4: disable write while line high drops pending; clear beats rise
        cur_req = "R4";
        wr(3, 32'h0000_1200); cyc(2); rd(0);
        wr(2, 32'h0000_1200); cyc(2); rd(0);
        src_in[10] = 1'b1;
        wr(3, 32'h0000_0400); cyc(2); rd(0);
        wr(2, 32'h0000_0400); cyc(2); rd(0);
        src_in = 0; cyc(2);

        // R10: timer lines on several CPUs share the timer source
        cur_req = "R10";
        wr(4, 0);
        tmr_in[2] = 1'b1; cyc(2); rd(0);
        tmr_in[1] = 1'b1; cyc(2);
        tmr_in[2] = 1'b0; cyc(2); rd(0);
        tmr_in = 4'b0101; cyc(2); rd(0);
        tmr_in = 4'b0000; cyc(2); rd(0);

        // R11: soft bits on every CPU, with and without global disable
        cur_req = "R11";
        soft_in = 64'h8001_4002_2004_1008; cyc(2);
        src_in[15] = 1'b1; cyc(2);
        wr(3, 32'h8000_0000); cyc(2);
        soft_in = 64'hFFFF_0000_00FF_0F0F; cyc(2);
        wr(2, 32'h8000_0000); cyc(2);
        soft_in = 0; src_in = 0; cyc(2);

        // R12: random traffic, checks timing and same-cycle orderings
        cur_req = "R12";
        for (int it = 0; it < 3000; it++) begin
            src_in  = src_in ^ ($urandom & $urandom & $urandom);
            tmr_in  = tmr_in ^ NCPU'($urandom & $urandom & $urandom);
            if ($urandom % 4 == 0) soft_in = {$urandom, $urandom} & {$urandom, $urandom};
            reg_vld   = ($urandom % 3 == 0);
            reg_wr    = $urandom % 2;
            reg_addr  = ADDR_W'($urandom);
            reg_wdata = $urandom;
            cyc();
        end
        reg_vld = 0;
        cyc(3);

        done = 1;
        summary();
        $finish;
    end

endmodule